// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase outputs and the once-per-turn index output of an incremental encoder into a position value. It brings Phase A, Phase B and the index into the clock domain with a two-flop synchronizer on each line. It then finds phase edges and decodes them in either a 2X or a 4X counting scheme. The result drives a 16-bit up/down position counter and a direction status bit.

The counter can wrap at a programmable maximum count. It can also be cleared by an index pulse, but only when the phase levels at that moment match a programmable pattern. In the index-clearing modes, the block watches for the count running past the expected range. When that happens it sets a sticky error flag and can raise a one-cycle error interrupt. Every index edge in those modes raises a one-cycle index interrupt.

The control inputs are plain register-style fields: mode, maximum count, match pattern, index-clear enable and error-interrupt disable. There is also a write strobe for the position and a write strobe for the error flag. An input change reaches the counter on the third rising clock edge after it is applied.

Top module: `qenc_position_top`

## Requirements
- R1: In 4X modes (modeSel[1]=1), every single-phase edge of the synchronized inputs changes the position by one. Phase A leading Phase B (AB sequence 00,10,11,01) increments the count and sets dirUp to 1. The reverse sequence decrements the count and sets dirUp to 0.
- R2: In 2X modes (modeSel[1]=0), only Phase A edges count. After the edge, the count goes up when A differs from B and down when A equals B; dirUp follows the same rule.
- R3: A cycle in which both synchronized phases change together produces no count.
- R4: Mode encoding: modeSel[2]=0 disables counting. 3'b100 is 2X with index clear, 3'b110 is 4X with index clear, 3'b101 is 2X with maximum wrap, and 3'b111 is 4X with maximum wrap.
- R5: In the maximum-wrap modes, counting up from maxCount gives 0 and counting down from 0 gives maxCount.
- R6: In 4X index-clear mode, a qualified index requires Phase B equal to matchVal[1] and Phase A equal to matchVal[0]. With idxResetEn=1, a qualified rising index edge clears the position to 0.
- R7: In 2X index-clear mode, matchVal[1] selects the phase to test (0 = A, 1 = B) and matchVal[0] gives the level it must have for the clear.
- R8: With idxResetEn=0, an index edge leaves the position unchanged. In the index-clear modes the counter wraps naturally at 16 bits, and that wrap sets no error.
- R9: idxIrq pulses for one cycle for every rising edge of the synchronized index while an index-clear mode is selected, and never in other modes.
- R10: In the index-clear modes, an up step that lands on maxCount+1, or a down step that lands on 0xFFFF, sets errFlag. The same step pulses errIrq for one cycle unless errIrqDis=1. Counting continues past the error, and other modes never flag one.
- R11: errFlag is sticky. A write with errWrEn loads errWrData into it, and a hardware error in the same cycle wins over the write.
- R12: posWrEn loads posWrData into the position on the next edge. This takes priority over a count or an index clear in the same cycle.
- R13: After reset, position, dirUp, errFlag, idxIrq and errIrq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | Encoder Phase A, asynchronous |
| phaseB | input | 1 | Encoder Phase B, asynchronous |
| indexIn | input | 1 | Encoder index, asynchronous |
| modeSel | input | 3 | Counting mode (see R4) |
| maxCount | input | 16 | Maximum count for wrap and error compare |
| matchVal | input | 2 | Index match pattern |
| idxResetEn | input | 1 | Allow qualified index to clear the count |
| errIrqDis | input | 1 | Suppress the error interrupt |
| posWrEn | input | 1 | Position write strobe |
| posWrData | input | 16 | Position write value |
| errWrEn | input | 1 | Error flag write strobe |
| errWrData | input | 1 | Error flag write value |
| position | output | 16 | Position count |
| dirUp | output | 1 | Direction of the last count, 1 = up |
| errFlag | output | 1 | Sticky count error flag |
| idxIrq | output | 1 | Index interrupt pulse |
| errIrq | output | 1 | Count error interrupt pulse |

## Verification
The hardest case to reach is a software position write that lands in the same cycle as a decoded count. The count arrives three edges after the phase change, so the stimulus toggles a phase and raises posWrEn exactly two falling edges later. The error compare at maxCount+1 and at 0xFFFF is reached by first writing a position next to the boundary, then stepping across it in each direction. The index qualification is exercised in both 2X and 4X modes while the phases are parked at a chosen level, with one matching pattern and at least one mismatching pattern each time.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef struct packed {
    logic step;      // one decoded count this cycle
    logic up;        // direction of that count
    logic idxEdge;   // index rising edge in an index-clear mode
    logic idxClear;  // qualified index with clearing enabled
    logic maxWrap;   // maximum-wrap mode active
    logic errCheck;  // error compare active
  } qenc_strobe_t;

  function automatic logic modeEnabled(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic modeIs4x(input logic [2:0] m);
    return m[1];
  endfunction

  function automatic logic modeIdx(input logic [2:0] m);
    return m[2] & ~m[0];
  endfunction

  function automatic logic modeMax(input logic [2:0] m);
    return m[2] & m[0];
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else if (s == 0) chain[s] <= asyncIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncA,
  input  logic         syncB,
  input  logic         syncIdx,
  input  logic [2:0]   modeSel,
  input  logic [1:0]   matchVal,
  input  logic         idxResetEn,
  output qenc_strobe_t strobe
);

  logic prevA, prevB, prevIdx;
  logic chgA, chgB, idxRise;
  logic step4x, step2x, up4x, up2x;
  logic matchHit, selPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA   <= 1'b0;
      prevB   <= 1'b0;
      prevIdx <= 1'b0;
    end else begin
      prevA   <= syncA;
      prevB   <= syncB;
      prevIdx <= syncIdx;
    end
  end

  always_comb begin
    chgA    = syncA ^ prevA;
    chgB    = syncB ^ prevB;
    idxRise = syncIdx & ~prevIdx;
    // legal single-phase changes only
    step4x  = chgA ^ chgB;
    up4x    = chgA ? (syncA != syncB) : (syncA == syncB);
    step2x  = chgA & ~chgB;
    up2x    = (syncA != syncB);
    selPhase = matchVal[1] ? syncB : syncA;
    if (modeIs4x(modeSel))
      matchHit = (syncB == matchVal[1]) && (syncA == matchVal[0]);
    else
      matchHit = (selPhase == matchVal[0]);
  end

  always_comb begin
    strobe.step     = modeEnabled(modeSel) & (modeIs4x(modeSel) ? step4x : step2x);
    strobe.up       = modeIs4x(modeSel) ? up4x : up2x;
    strobe.idxEdge  = modeIdx(modeSel) & idxRise;
    strobe.idxClear = modeIdx(modeSel) & idxRise & idxResetEn & matchHit;
    strobe.maxWrap  = modeMax(modeSel);
    strobe.errCheck = modeIdx(modeSel);
  end

endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qenc_strobe_t     strobe,
  input  logic [CNT_W-1:0] maxCount,
  input  logic             errIrqDis,
  input  logic             posWrEn,
  input  logic [CNT_W-1:0] posWrData,
  input  logic             errWrEn,
  input  logic             errWrData,
  output logic [CNT_W-1:0] position,
  output logic             dirUp,
  output logic             errFlag,
  output logic             idxIrq,
  output logic             errIrq
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] stepVal, posNext, maxPlus;
  logic             errHit;

  always_comb begin
    maxPlus = maxCount + ONE;
    if (strobe.up)
      stepVal = (strobe.maxWrap && position == maxCount) ? '0 : position + ONE;
    else
      stepVal = (strobe.maxWrap && position == '0) ? maxCount : position - ONE;

    posNext = position;
    if (strobe.step)     posNext = stepVal;
    if (strobe.idxClear) posNext = '0;
    if (posWrEn)         posNext = posWrData;

    errHit = strobe.errCheck && strobe.step && !strobe.idxClear && !posWrEn &&
             ((strobe.up && stepVal == maxPlus) || (!strobe.up && stepVal == ALL_ONES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      position <= '0;
      dirUp    <= 1'b0;
      errFlag  <= 1'b0;
      idxIrq   <= 1'b0;
      errIrq   <= 1'b0;
    end else begin
      position <= posNext;
      if (strobe.step) dirUp <= strobe.up;
      if (errHit)       errFlag <= 1'b1;
      else if (errWrEn) errFlag <= errWrData;
      idxIrq <= strobe.idxEdge;
      errIrq <= errHit && !errIrqDis;
    end
  end

endmodule

// File: rtl/qenc_position_top.sv
module qenc_position_top
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             indexIn,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] maxCount,
  input  logic [1:0]       matchVal,
  input  logic             idxResetEn,
  input  logic             errIrqDis,
  input  logic             posWrEn,
  input  logic [CNT_W-1:0] posWrData,
  input  logic             errWrEn,
  input  logic             errWrData,
  output logic [CNT_W-1:0] position,
  output logic             dirUp,
  output logic             errFlag,
  output logic             idxIrq,
  output logic             errIrq
);

  localparam int NUM_LINES = 3;

  logic [NUM_LINES-1:0] syncLines;
  qenc_strobe_t         strobe;

  qenc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({indexIn, phaseB, phaseA}),
    .syncOut (syncLines)
  );

  qenc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncA      (syncLines[0]),
    .syncB      (syncLines[1]),
    .syncIdx    (syncLines[2]),
    .modeSel    (modeSel),
    .matchVal   (matchVal),
    .idxResetEn (idxResetEn),
    .strobe     (strobe)
  );

  qenc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .maxCount  (maxCount),
    .errIrqDis (errIrqDis),
    .posWrEn   (posWrEn),
    .posWrData (posWrData),
    .errWrEn   (errWrEn),
    .errWrData (errWrData),
    .position  (position),
    .dirUp     (dirUp),
    .errFlag   (errFlag),
    .idxIrq    (idxIrq),
    .errIrq    (errIrq)
  );

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       modeSel,
  input logic             errIrqDis,
  input logic             errWrEn,
  input logic             posWrEn,
  input logic [CNT_W-1:0] posWrData,
  input logic [CNT_W-1:0] position,
  input logic             errFlag,
  input logic             errIrq,
  input logic             idxIrq
);

  assert_wr_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    posWrEn |=> position == $past(posWrData));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errWrEn |=> errFlag);

  assert_err_irq_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> errFlag && !$past(errIrqDis));

  assert_err_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> ($past(modeSel) == 3'b100 || $past(modeSel) == 3'b110));

  assert_idx_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    idxIrq |-> ($past(modeSel) == 3'b100 || $past(modeSel) == 3'b110));

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modeSel[2]) && !$past(posWrEn) |-> $stable(position));

endmodule

bind qenc_position_top qenc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .errIrqDis (errIrqDis),
  .errWrEn   (errWrEn),
  .posWrEn   (posWrEn),
  .posWrData (posWrData),
  .position  (position),
  .errFlag   (errFlag),
  .errIrq    (errIrq),
  .idxIrq    (idxIrq)
);

// File: tb/tb_qenc_position_top.sv
`timescale 1ns/1ps
module tb_qenc_position_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0;
  logic [2:0]  modeSel = 3'b000;
  logic [15:0] maxCount = 16'd100;
  logic [1:0]  matchVal = 2'b00;
  logic        idxResetEn = 1'b0, errIrqDis = 1'b0;
  logic        posWrEn = 1'b0, errWrEn = 1'b0, errWrData = 1'b0;
  logic [15:0] posWrData = '0;
  logic [15:0] position;
  logic        dirUp, errFlag, idxIrq, errIrq;

  always #4 clk = ~clk;

  qenc_position_top dut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn),
    .modeSel(modeSel), .maxCount(maxCount), .matchVal(matchVal),
    .idxResetEn(idxResetEn), .errIrqDis(errIrqDis), .posWrEn(posWrEn),
    .posWrData(posWrData), .errWrEn(errWrEn), .errWrData(errWrData),
    .position(position), .dirUp(dirUp), .errFlag(errFlag),
    .idxIrq(idxIrq), .errIrq(errIrq)
  );

  typedef enum int {K_POS, K_DIR, K_ERR, K_IDXCNT, K_ERRCNT} kind_t;
  typedef struct {
    string tag;
    kind_t kind;
    int    expVal;
  } item_t;

  item_t queueSb[$];
  int    checks = 0, errors = 0;
  int    idxCnt = 0, errCnt = 0;
  int    gstate = 0;
  bit    done = 0;

  always @(posedge clk) begin
    if (idxIrq) idxCnt++;
    if (errIrq) errCnt++;
  end

  // monitor: compares each expected item as soon as it is queued
  initial begin
    forever begin
      item_t it;
      int    act;
      wait (queueSb.size() > 0);
      it = queueSb.pop_front();
      case (it.kind)
        K_POS:    act = int'(position);
        K_DIR:    act = int'(dirUp);
        K_ERR:    act = int'(errFlag);
        K_IDXCNT: act = idxCnt;
        default:  act = errCnt;
      endcase
      checks++;
      if (act !== it.expVal) begin
        errors++;
        $display("FAIL %s: kind %0d actual %0d expected %0d", it.tag, it.kind, act, it.expVal);
      end
    end
  end

  task automatic expect_(input string tag, input kind_t k, input int v);
    item_t it;
    it.tag = tag; it.kind = k; it.expVal = v;
    queueSb.push_back(it);
    #0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic setPhases(input int st);
    // forward Gray order of AB: 00,10,11,01
    gstate = st;
    phaseA = (st == 1 || st == 2);
    phaseB = (st == 2 || st == 3);
  endtask

  task automatic fwd();
    setPhases((gstate + 1) % 4);
    settle();
  endtask

  task automatic rev();
    setPhases((gstate + 3) % 4);
    settle();
  endtask

  task automatic writePos(input logic [15:0] v);
    @(negedge clk);
    posWrEn = 1'b1; posWrData = v;
    @(negedge clk);
    posWrEn = 1'b0;
  endtask

  task automatic writeErr(input logic v);
    @(negedge clk);
    errWrEn = 1'b1; errWrData = v;
    @(negedge clk);
    errWrEn = 1'b0;
  endtask

  task automatic pulseIndex();
    @(negedge clk);
    indexIn = 1'b1;
    repeat (2) @(negedge clk);
    indexIn = 1'b0;
    settle();
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_("R13 reset position", K_POS, 0);
    expect_("R13 reset dir", K_DIR, 0);
    expect_("R13 reset err", K_ERR, 0);
    rstN = 1'b1;
    @(negedge clk);

    // 4X index mode, clearing disabled
    modeSel = 3'b110; maxCount = 16'd100;
    repeat (4) fwd();
    expect_("R1 four forward edges", K_POS, 4);
    expect_("R1 forward dir", K_DIR, 1);
    rev();
    expect_("R1 reverse edge", K_POS, 3);
    expect_("R1 reverse dir", K_DIR, 0);

    // both phases flip at once (01 -> 10 -> 01)
    setPhases(1); settle();
    expect_("R3 illegal jump ignored", K_POS, 3);
    setPhases(3); settle();
    expect_("R3 illegal jump back ignored", K_POS, 3);

    writePos(16'd99);
    expect_("R12 write", K_POS, 99);
    fwd();
    expect_("R10 below bound", K_ERR, 0);
    fwd();
    expect_("R10 up to maxCount+1 pos", K_POS, 101);
    expect_("R10 up error flag", K_ERR, 1);
    expect_("R10 up error irq", K_ERRCNT, 1);
    fwd();
    expect_("R10 counting continues", K_POS, 102);
    expect_("R11 flag sticky", K_ERR, 1);
    writeErr(1'b0);
    expect_("R11 software clear", K_ERR, 0);

    writePos(16'd0);
    rev();
    expect_("R10 down to 0xFFFF", K_POS, 65535);
    expect_("R10 down error flag", K_ERR, 1);
    expect_("R10 down error irq", K_ERRCNT, 2);
    writeErr(1'b0);
    errIrqDis = 1'b1;
    writePos(16'd0);
    rev();
    expect_("R10 flag with irq disabled", K_ERR, 1);
    expect_("R10 irq suppressed", K_ERRCNT, 2);
    errIrqDis = 1'b0;
    writeErr(1'b0);
    writeErr(1'b1);
    expect_("R11 software set", K_ERR, 1);
    writeErr(1'b0);

    // phases now 00, clearing disabled
    pulseIndex();
    expect_("R8 index without clear", K_POS, 65535);
    expect_("R9 index irq", K_IDXCNT, 1);
    fwd();
    expect_("R8 natural wrap", K_POS, 0);
    expect_("R8 wrap sets no error", K_ERR, 0);

    // phases 10 (A=1,B=0): 4X match
    idxResetEn = 1'b1;
    writePos(16'd50);
    matchVal = 2'b10;
    pulseIndex();
    expect_("R6 4X mismatch no clear", K_POS, 50);
    matchVal = 2'b01;
    pulseIndex();
    expect_("R6 4X match clears", K_POS, 0);
    expect_("R9 index irq count", K_IDXCNT, 3);

    // 2X index mode, same phases
    modeSel = 3'b100;
    writePos(16'd50);
    matchVal = 2'b11;
    pulseIndex();
    expect_("R7 2X phase B high mismatch", K_POS, 50);
    matchVal = 2'b10;
    pulseIndex();
    expect_("R7 2X phase B low clears", K_POS, 0);
    writePos(16'd50);
    matchVal = 2'b00;
    pulseIndex();
    expect_("R7 2X phase A low mismatch", K_POS, 50);
    expect_("R9 2X index irqs", K_IDXCNT, 6);

    idxResetEn = 1'b0;
    writePos(16'd10);
    repeat (4) fwd();
    expect_("R2 2X full forward cycle", K_POS, 12);
    expect_("R2 2X forward dir", K_DIR, 1);
    repeat (4) rev();
    expect_("R2 2X full reverse cycle", K_POS, 10);
    expect_("R2 2X reverse dir", K_DIR, 0);

    // 4X maximum wrap
    modeSel = 3'b111; maxCount = 16'd5;
    writePos(16'd4);
    fwd();
    expect_("R5 reach max", K_POS, 5);
    fwd();
    expect_("R5 wrap to zero", K_POS, 0);
    rev();
    expect_("R5 under to max", K_POS, 5);
    expect_("R10 no error in max mode", K_ERRCNT, 2);
    pulseIndex();
    expect_("R9 no index irq in max mode", K_IDXCNT, 6);

    modeSel = 3'b000;
    fwd(); fwd();
    expect_("R4 disabled mode holds", K_POS, 5);

    // write lands in the same cycle as a count
    modeSel = 3'b110; maxCount = 16'd100;
    setPhases((gstate + 1) % 4);
    repeat (2) @(negedge clk);
    posWrEn = 1'b1; posWrData = 16'd77;
    @(negedge clk);
    posWrEn = 1'b0;
    settle();
    expect_("R12 write beats count", K_POS, 77);
    fwd();
    expect_("R12 count after write", K_POS, 78);

    repeat (2) @(negedge clk);
    done = 1;
    finishRun();
  end

endmodule